// File: doc/BRIEF.md
# Tiered Interrupt Arbiter with Per-Source Service Routing

This block turns a set of pending interrupt requests into one service decision per cycle. Each maskable source has a pending bit, a mask bit, a route bit and a done bit. The route bit sends an accepted request either to a microcoded transfer channel or to an ordinary service routine. The done bit holds an end-of-transfer request that the transfer channel raises for that source. A global interrupt-enable flag and a separate transfer-channel enable flag gate the maskable sources. Single-cycle strobes set and clear both flags.

Arbitration uses three fixed tiers: the non-maskable request first, then requests routed to the transfer channel, then standard requests. Inside a tier the higher source number wins. Two exception inputs, undefined opcode and software trap, are not arbitrated. They override every other decision in the same cycle and leave all state as it was. The outputs are a valid flag, a service kind, the winning source index and a vector address. An acknowledge, sampled at the clock edge, retires the granted request. Fetching from the vector and saving context are done elsewhere.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While reset is high and after reset is released, all pending, mask, route and done bits are zero, both enable flags are off and the NMI latch is empty. With no exception input, `irq_valid_o` is 0.
- R2: A pulse on `req_i[i]` sets pending bit i at the clock edge. When mask i is 1, route i is 0 and interrupts are enabled, the outputs from the next cycle are valid, kind 0 (standard), source i and vector 16'h2000 + 2*i.
- R3: Among several eligible requests of one tier, the highest source index is presented.
- R4: The NMI input latches a request that is presented as kind 2, source 0, vector 16'h203E. It ignores the mask, the route bits and both enable flags, and it outranks every maskable request.
- R5: A request with route bit 1, mask bit 1 and both flags enabled is presented as kind 1 (transfer), source i, vector 16'h2040 + 2*i. It outranks every standard request, whatever the index.
- R6: With the transfer flag off, a routed request is not presented in any tier and stays pending. It is served once the flag is enabled again.
- R7: A request whose mask bit is 0 is not presented and stays pending until the mask bit is set.
- R8: With the interrupt flag off, no standard or transfer request is presented. NMI and the exceptions still are.
- R9: Strobes `ei_i`/`di_i` set/clear the interrupt flag, and `epts_i`/`dpts_i` set/clear the transfer flag. When both strobes of a pair are high together, the clear wins.
- R10: An acknowledge while the output is valid clears, at that edge, only the pending (or done, or NMI) bit of the presented request. A hardware set of the same bit in that cycle wins over the clear.
- R11: `exc_undef_i` presents kind 3, source 0, vector 16'h2012, and `exc_trap_i` presents kind 3, source 1, vector 16'h2010. Both act in the same cycle, above every other request, with undefined opcode above trap. Neither changes any state, even when acknowledged.
- R12: A pulse on `done_i[i]` sets done bit i. A set done bit is a standard-tier request (kind 0, vector 16'h2000 + 2*i) gated by mask i and the interrupt flag, regardless of route i and the transfer flag. Acknowledging it clears the done bit.
- R13: With `wr_en_i` high, `wr_data_i` replaces one register at the edge, chosen by `wr_sel_i`: 0 mask, 1 route, 2 pending, 3 done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | N_SRC | Hardware request pulses, one per source |
| nmi_i | input | 1 | Non-maskable request |
| done_i | input | N_SRC | End-of-transfer request pulses, one per source |
| exc_undef_i | input | 1 | Undefined-opcode exception |
| exc_trap_i | input | 1 | Software trap exception |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register chosen for the write |
| wr_data_i | input | N_SRC | Write data |
| ei_i | input | 1 | Set interrupt enable |
| di_i | input | 1 | Clear interrupt enable |
| epts_i | input | 1 | Set transfer-channel enable |
| dpts_i | input | 1 | Clear transfer-channel enable |
| ack_i | input | 1 | Acknowledge of the presented request |
| irq_valid_o | output | 1 | A request is presented |
| irq_kind_o | output | 2 | 0 standard, 1 transfer, 2 NMI, 3 exception |
| irq_src_o | output | SRC_W | Winning source index |
| irq_vec_o | output | 16 | Vector address |

## Verification
On every cycle, the assertions check the gating of the presented request: a standard or transfer kind never appears with the interrupt flag off, a transfer kind never appears with the transfer flag off, and the presented maskable source is always unmasked. They also check that a pending NMI and an undefined-opcode exception are presented at once, that a clear strobe beats its set strobe, and that an acknowledged NMI retires. Some behaviour only the bench's scenarios can show. These are the ordering of every source pair within the standard tier and across tiers, routed requests held while the transfer flag is off and later released, same-edge set-versus-clear on acknowledge, and exceptions leaving the pending state untouched.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

    localparam int VEC_W = 16;

    typedef enum logic [1:0] {
        KIND_STD  = 2'd0,
        KIND_XFER = 2'd1,
        KIND_NMI  = 2'd2,
        KIND_EXC  = 2'd3
    } svc_kind_e;

    typedef enum logic [1:0] {
        REG_MASK  = 2'd0,
        REG_ROUTE = 2'd1,
        REG_PEND  = 2'd2,
        REG_DONE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic ie;
        logic xfer_en;
    } gate_t;

    typedef struct packed {
        logic                 valid;
        svc_kind_e            kind;
        logic [VEC_W-1:0]     vec;
    } grant_t;

    // Vector slot: two bytes per source above a base address.
    function automatic logic [VEC_W-1:0] slot_addr(input logic [VEC_W-1:0] base,
                                                   input logic [7:0] idx);
        return base + {{(VEC_W-9){1'b0}}, idx, 1'b0};
    endfunction

endpackage

// File: rtl/pic_hi_find.sv
module pic_hi_find #(
    parameter int N = 31,
    parameter int W = 5
) (
    input  logic [N-1:0] req,
    output logic         hit,
    output logic [W-1:0] idx
);
    // Ascending scan: the last set bit seen is the highest index.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int k = 0; k < N; k++) begin
            if (req[k]) begin
                hit = 1'b1;
                idx = W'(k);
            end
        end
    end
endmodule

// File: rtl/pic_src_bank.sv
module pic_src_bank
    import prio_irq_pkg::*;
#(
    parameter int N = 31
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] hw_req,
    input  logic [N-1:0] done_req,
    input  logic         wr_en,
    input  reg_sel_e     wr_sel,
    input  logic [N-1:0] wr_data,
    input  logic [N-1:0] clr_pend,
    input  logic [N-1:0] clr_done,
    output logic [N-1:0] pend_o,
    output logic [N-1:0] mask_o,
    output logic [N-1:0] route_o,
    output logic [N-1:0] done_o
);
    logic wr_mask, wr_route, wr_pend, wr_done;

    always_comb begin
        wr_mask  = wr_en && (wr_sel == REG_MASK);
        wr_route = wr_en && (wr_sel == REG_ROUTE);
        wr_pend  = wr_en && (wr_sel == REG_PEND);
        wr_done  = wr_en && (wr_sel == REG_DONE);
    end

    for (genvar g = 0; g < N; g++) begin : g_bit
        logic m_q, r_q, p_q, d_q;
        logic p_base, d_base;

        always_comb begin
            p_base = wr_pend ? wr_data[g] : p_q;
            d_base = wr_done ? wr_data[g] : d_q;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                m_q <= 1'b0;
                r_q <= 1'b0;
                p_q <= 1'b0;
                d_q <= 1'b0;
            end else begin
                if (wr_mask)  m_q <= wr_data[g];
                if (wr_route) r_q <= wr_data[g];
                // hardware set outranks both the write and the acknowledge clear
                p_q <= (p_base & ~clr_pend[g]) | hw_req[g];
                d_q <= (d_base & ~clr_done[g]) | done_req[g];
            end
        end

        assign mask_o[g]  = m_q;
        assign route_o[g] = r_q;
        assign pend_o[g]  = p_q;
        assign done_o[g]  = d_q;
    end
endmodule

// File: rtl/pic_status.sv
module pic_status
    import prio_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ei,
    input  logic  di,
    input  logic  epts,
    input  logic  dpts,
    output gate_t gate_o
);
    gate_t gate_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= '0;
        end else begin
            if (di)        gate_q.ie <= 1'b0;
            else if (ei)   gate_q.ie <= 1'b1;
            if (dpts)      gate_q.xfer_en <= 1'b0;
            else if (epts) gate_q.xfer_en <= 1'b1;
        end
    end

    assign gate_o = gate_q;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int                N_SRC     = 31,
    parameter logic [VEC_W-1:0]  STD_BASE  = 16'h2000,
    parameter logic [VEC_W-1:0]  XFER_BASE = 16'h2040,
    parameter logic [VEC_W-1:0]  NMI_VEC   = 16'h203E,
    parameter logic [VEC_W-1:0]  UNDEF_VEC = 16'h2012,
    parameter logic [VEC_W-1:0]  TRAP_VEC  = 16'h2010,
    localparam int               SRC_W     = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  req_i,
    input  logic              nmi_i,
    input  logic [N_SRC-1:0]  done_i,
    input  logic              exc_undef_i,
    input  logic              exc_trap_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_sel_i,
    input  logic [N_SRC-1:0]  wr_data_i,
    input  logic              ei_i,
    input  logic              di_i,
    input  logic              epts_i,
    input  logic              dpts_i,
    input  logic              ack_i,
    output logic              irq_valid_o,
    output logic [1:0]        irq_kind_o,
    output logic [SRC_W-1:0]  irq_src_o,
    output logic [VEC_W-1:0]  irq_vec_o
);
    gate_t               gate;
    logic                ie_q, xfer_en_q;
    logic [N_SRC-1:0]    pend, mask, route, done;
    logic [N_SRC-1:0]    xfer_req, std_req;
    logic [N_SRC-1:0]    grant_oh, clr_pend, clr_done;
    logic                xfer_hit, std_hit;
    logic [SRC_W-1:0]    xfer_idx, std_idx;
    logic                nmi_pend;
    logic                fire;
    grant_t              gr;
    logic [SRC_W-1:0]    gr_src;

    pic_status u_status (
        .clk    (clk),
        .rst    (rst),
        .ei     (ei_i),
        .di     (di_i),
        .epts   (epts_i),
        .dpts   (dpts_i),
        .gate_o (gate)
    );

    assign ie_q      = gate.ie;
    assign xfer_en_q = gate.xfer_en;

    pic_src_bank #(.N(N_SRC)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .hw_req   (req_i),
        .done_req (done_i),
        .wr_en    (wr_en_i),
        .wr_sel   (reg_sel_e'(wr_sel_i)),
        .wr_data  (wr_data_i),
        .clr_pend (clr_pend),
        .clr_done (clr_done),
        .pend_o   (pend),
        .mask_o   (mask),
        .route_o  (route),
        .done_o   (done)
    );

    // Tier request vectors
    always_comb begin
        xfer_req = pend & route & mask & {N_SRC{ie_q & xfer_en_q}};
        std_req  = ((pend & ~route) | done) & mask & {N_SRC{ie_q}};
    end

    pic_hi_find #(.N(N_SRC), .W(SRC_W)) u_find_xfer (
        .req (xfer_req),
        .hit (xfer_hit),
        .idx (xfer_idx)
    );

    pic_hi_find #(.N(N_SRC), .W(SRC_W)) u_find_std (
        .req (std_req),
        .hit (std_hit),
        .idx (std_idx)
    );

    // Tier selection: exceptions, NMI, transfer, standard
    always_comb begin
        gr     = '0;
        gr_src = '0;
        if (exc_undef_i) begin
            gr = '{valid: 1'b1, kind: KIND_EXC, vec: UNDEF_VEC};
        end else if (exc_trap_i) begin
            gr     = '{valid: 1'b1, kind: KIND_EXC, vec: TRAP_VEC};
            gr_src = SRC_W'(1);
        end else if (nmi_pend) begin
            gr = '{valid: 1'b1, kind: KIND_NMI, vec: NMI_VEC};
        end else if (xfer_hit) begin
            gr     = '{valid: 1'b1, kind: KIND_XFER,
                       vec: slot_addr(XFER_BASE, 8'(xfer_idx))};
            gr_src = xfer_idx;
        end else if (std_hit) begin
            gr     = '{valid: 1'b1, kind: KIND_STD,
                       vec: slot_addr(STD_BASE, 8'(std_idx))};
            gr_src = std_idx;
        end
    end

    // Retirement of the presented request
    always_comb begin
        fire     = ack_i & gr.valid;
        grant_oh = {{(N_SRC-1){1'b0}}, 1'b1} << gr_src;
        clr_pend = '0;
        clr_done = '0;
        if (fire && gr.kind == KIND_XFER) begin
            clr_pend = grant_oh;
        end else if (fire && gr.kind == KIND_STD) begin
            clr_pend = grant_oh & ~route;
            clr_done = grant_oh;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_pend <= 1'b0;
        end else begin
            nmi_pend <= (nmi_pend & ~(fire && gr.kind == KIND_NMI)) | nmi_i;
        end
    end

    assign irq_valid_o = gr.valid;
    assign irq_kind_o  = gr.kind;
    assign irq_src_o   = gr_src;
    assign irq_vec_o   = gr.vec;

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk
    import prio_irq_pkg::*;
#(
    parameter int N_SRC = 31,
    parameter int SRC_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             exc_undef_i,
    input logic             exc_trap_i,
    input logic             nmi_i,
    input logic             ack_i,
    input logic             di_i,
    input logic             dpts_i,
    input logic             irq_valid_o,
    input logic [1:0]       irq_kind_o,
    input logic [SRC_W-1:0] irq_src_o,
    input logic             ie_q,
    input logic             xfer_en_q,
    input logic             nmi_pend,
    input logic [N_SRC-1:0] mask
);
    logic maskable_out;
    assign maskable_out = irq_valid_o &&
        (irq_kind_o == KIND_STD || irq_kind_o == KIND_XFER);

    a_r1_reset_clean: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!ie_q && !xfer_en_q && !nmi_pend && mask == '0));

    a_r11_undef_first: assert property (@(posedge clk) disable iff (rst)
        exc_undef_i |-> (irq_valid_o && irq_kind_o == KIND_EXC && irq_src_o == '0));

    a_r4_nmi_first: assert property (@(posedge clk) disable iff (rst)
        (nmi_pend && !exc_undef_i && !exc_trap_i) |-> (irq_valid_o && irq_kind_o == KIND_NMI));

    a_r8_needs_ie: assert property (@(posedge clk) disable iff (rst)
        maskable_out |-> ie_q);

    a_r6_xfer_needs_en: assert property (@(posedge clk) disable iff (rst)
        (irq_valid_o && irq_kind_o == KIND_XFER) |-> xfer_en_q);

    a_r7_unmasked_only: assert property (@(posedge clk) disable iff (rst)
        maskable_out |-> mask[irq_src_o]);

    a_r9_di_wins: assert property (@(posedge clk) disable iff (rst)
        di_i |=> !ie_q);

    a_r9_dpts_wins: assert property (@(posedge clk) disable iff (rst)
        dpts_i |=> !xfer_en_q);

    a_r10_nmi_retire: assert property (@(posedge clk) disable iff (rst)
        (irq_valid_o && irq_kind_o == KIND_NMI && ack_i && !nmi_i) |=> !nmi_pend);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.N_SRC(N_SRC), .SRC_W(SRC_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .exc_undef_i (exc_undef_i),
    .exc_trap_i  (exc_trap_i),
    .nmi_i       (nmi_i),
    .ack_i       (ack_i),
    .di_i        (di_i),
    .dpts_i      (dpts_i),
    .irq_valid_o (irq_valid_o),
    .irq_kind_o  (irq_kind_o),
    .irq_src_o   (irq_src_o),
    .ie_q        (ie_q),
    .xfer_en_q   (xfer_en_q),
    .nmi_pend    (nmi_pend),
    .mask        (mask)
);

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb;
    localparam int N = 31;
    localparam int SW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  req = '0, done = '0, wdata = '0;
    logic          nmi = 0, undef = 0, trap = 0, wen = 0;
    logic [1:0]    wsel = '0;
    logic          ei = 0, di = 0, epts = 0, dpts = 0, ack = 0;
    logic          vld;
    logic [1:0]    kind;
    logic [SW-1:0] src;
    logic [15:0]   vec;

    int total = 0, bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    prio_irq_ctrl u_dut (
        .clk(clk), .rst(rst), .req_i(req), .nmi_i(nmi), .done_i(done),
        .exc_undef_i(undef), .exc_trap_i(trap), .wr_en_i(wen), .wr_sel_i(wsel),
        .wr_data_i(wdata), .ei_i(ei), .di_i(di), .epts_i(epts), .dpts_i(dpts),
        .ack_i(ack), .irq_valid_o(vld), .irq_kind_o(kind), .irq_src_o(src),
        .irq_vec_o(vec)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [15:0] std_vec(input int i);
        return 16'h2000 + 16'(2 * i);
    endfunction

    function automatic logic [15:0] xfer_vec(input int i);
        return 16'h2040 + 16'(2 * i);
    endfunction

    task automatic expect_out(input string tag, input logic ev, input logic [1:0] ek,
                              input int es, input logic [15:0] evec);
        total++;
        if (vld !== ev || (ev && (kind !== ek || src !== SW'(es) || vec !== evec))) begin
            bad++;
            $display("FAIL %s: got v=%0b k=%0d s=%0d vec=%h, expected v=%0b k=%0d s=%0d vec=%h",
                     tag, vld, kind, src, vec, ev, ek, es, evec);
        end
    endtask

    task automatic write_reg(input logic [1:0] s, input logic [N-1:0] d);
        wen = 1; wsel = s; wdata = d;
        tick();
        wen = 0; wdata = '0;
    endtask

    task automatic pulse_req(input logic [N-1:0] r);
        req = r;
        tick();
        req = '0;
    endtask

    task automatic clean();
        write_reg(2'd2, '0);
        write_reg(2'd3, '0);
        write_reg(2'd1, '0);
    endtask

    task automatic do_ack();
        ack = 1;
        tick();
        ack = 0;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: run did not complete");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        // R1: reset state
        expect_out("R1 during reset", 0, 0, 0, 0);
        rst = 0;
        tick();
        expect_out("R1 after reset", 0, 0, 0, 0);
        write_reg(2'd0, '1);
        pulse_req(N'(1) << 5);
        // R8: interrupt flag off blocks standard
        expect_out("R8 ie off", 0, 0, 0, 0);
        ei = 1; tick(); ei = 0;
        // R2: basic standard grant
        expect_out("R2 std src5", 1, 2'd0, 5, std_vec(5));
        clean();

        // R3: exhaustive pairs in the standard tier
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                write_reg(2'd2, '0);
                pulse_req((N'(1) << i) | (N'(1) << j));
                expect_out("R3 std pair", 1, 2'd0, (i > j) ? i : j, std_vec((i > j) ? i : j));
            end
        end
        write_reg(2'd2, '0);

        // R5: a routed request beats any standard one
        epts = 1; tick(); epts = 0;
        for (int i = 0; i < N; i++) begin
            write_reg(2'd1, N'(1) << i);
            for (int j = 0; j < N; j++) begin
                if (j != i) begin
                    write_reg(2'd2, '0);
                    pulse_req((N'(1) << i) | (N'(1) << j));
                    expect_out("R5 xfer tier", 1, 2'd1, i, xfer_vec(i));
                end
            end
        end
        clean();

        // R6: transfer disabled holds routed request
        write_reg(2'd1, N'(1) << 20);
        dpts = 1; tick(); dpts = 0;
        pulse_req((N'(1) << 20) | (N'(1) << 3));
        expect_out("R6 std served while xfer off", 1, 2'd0, 3, std_vec(3));
        do_ack();
        expect_out("R6 routed held, not served", 0, 0, 0, 0);
        epts = 1; tick(); epts = 0;
        expect_out("R6 routed released", 1, 2'd1, 20, xfer_vec(20));
        do_ack();
        expect_out("R10 xfer retired", 0, 0, 0, 0);
        clean();

        // R7: mask holds pending
        write_reg(2'd0, ~(N'(1) << 12));
        pulse_req(N'(1) << 12);
        expect_out("R7 masked", 0, 0, 0, 0);
        write_reg(2'd0, '1);
        expect_out("R7 unmasked", 1, 2'd0, 12, std_vec(12));
        clean();

        // R4: NMI outranks, ignores flags
        pulse_req(N'(1) << 30);
        di = 1; nmi = 1; tick(); di = 0; nmi = 0;
        expect_out("R4 nmi ie off", 1, 2'd2, 0, 16'h203E);
        ei = 1; tick(); ei = 0;
        expect_out("R4 nmi over std30", 1, 2'd2, 0, 16'h203E);
        do_ack();
        expect_out("R10 nmi retired", 1, 2'd0, 30, std_vec(30));
        clean();

        // R10: ack clears only granted bit, same-edge set wins
        pulse_req((N'(1) << 3) | (N'(1) << 7));
        expect_out("R10 top", 1, 2'd0, 7, std_vec(7));
        do_ack();
        expect_out("R10 next", 1, 2'd0, 3, std_vec(3));
        ack = 1; req = N'(1) << 3; tick(); ack = 0; req = '0;
        expect_out("R10 set beats clear", 1, 2'd0, 3, std_vec(3));
        do_ack();
        expect_out("R10 empty", 0, 0, 0, 0);

        // R11: exceptions bypass and leave state alone
        pulse_req(N'(1) << 9);
        undef = 1; #1;
        expect_out("R11 undef", 1, 2'd3, 0, 16'h2012);
        trap = 1; #1;
        expect_out("R11 undef over trap", 1, 2'd3, 0, 16'h2012);
        undef = 0; #1;
        expect_out("R11 trap", 1, 2'd3, 1, 16'h2010);
        ack = 1; tick(); ack = 0; trap = 0; #1;
        expect_out("R11 no state change", 1, 2'd0, 9, std_vec(9));
        clean();

        // R12: done bit is standard request regardless of route/xfer flag
        write_reg(2'd1, N'(1) << 9);
        dpts = 1; tick(); dpts = 0;
        done = N'(1) << 9; tick(); done = '0;
        expect_out("R12 done served", 1, 2'd0, 9, std_vec(9));
        do_ack();
        expect_out("R12 done cleared", 0, 0, 0, 0);
        clean();

        // R9: clear beats set
        ei = 1; di = 1; tick(); ei = 0; di = 0;
        pulse_req(N'(1) << 2);
        expect_out("R9 di wins", 0, 0, 0, 0);
        ei = 1; tick(); ei = 0;
        write_reg(2'd1, N'(1) << 2);
        epts = 1; dpts = 1; tick(); epts = 0; dpts = 0;
        expect_out("R9 dpts wins", 0, 0, 0, 0);
        epts = 1; tick(); epts = 0;
        expect_out("R9 epts sets", 1, 2'd1, 2, xfer_vec(2));
        clean();

        // R13: direct writes to pending and done
        write_reg(2'd2, N'(1) << 4);
        expect_out("R13 pend write", 1, 2'd0, 4, std_vec(4));
        write_reg(2'd2, '0);
        expect_out("R13 pend clear", 0, 0, 0, 0);
        write_reg(2'd3, N'(1) << 6);
        expect_out("R13 done write", 1, 2'd0, 6, std_vec(6));
        clean();

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule